// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the software-visible register file of an Ethernet MAC. A host reaches it through a simple 32-bit bus. Each access has a byte offset, a size code, a write strobe or a read strobe, and write data. Read data and an error flag come back one cycle later. The bank holds the operating mode, station address, hash filter, VLAN tags, system control, interrupt enables and statistics-counter control. It also holds the live and sticky receive and transmit status words, the system status word, the wakeup control word and the counter-interrupt status words.

The frame datapath drives the bank through one-cycle set pulses, one pulse input for each status word, and through increment strobes, one strobe for each statistics counter. The bank returns the receive-enable and transmit-enable bits of the operating mode as plain outputs. Each register has its own write rule: ordinary store, masked write-one-to-clear, read-only, or clear-all-counters. Some mode writes also clear status bits.

Top module: `emac_reg_bank`

## Requirements
- R1: An access is legal only when its size code is 2 (a 32-bit word). Any other size raises the error flag and returns zero read data, and a write of that size changes nothing. The size check comes before address decoding, so an access with a bad size to the time window also raises the error.
- R2: After reset the registers hold these values: station address low (0x04) 0xFFFFFFFF, station address high (0x08) 0x0000FFFF, VLAN registers (0x14, 0x18) 0x0000FFFF, system control (0x1C) 0x00003F00, counter control (0x40) 0x0000000A. Every other register reads 0, and the rx_en and tx_en outputs are 0.
- R3: Mode register (0x00): bit 0 is receive enable and bit 1 is transmit enable. A write that changes bit 0 from 0 to 1 clears bit 0 (the "complete" bit) of the live RX status (0x28). A write that changes bit 1 from 0 to 1 clears bit 0 of the live TX status (0x34). A write that leaves an enable bit at 1 clears nothing.
- R4: System status (0x20) is set by sys_stat_set. Writing a 1 clears only the bits in mask 0x000000E1. Writes leave all other bits unchanged.
- R5: Wakeup control (0x24): the bits in mask 0x00000F20 are set by wake_set and cleared by writing a 1. All other bits store the written value.
- R6: Sticky RX status (0x2C), sticky TX status (0x38), RX counter-interrupt status (0x44) and TX counter-interrupt status (0x4C) are set by their set inputs and cleared by writing a 1, on all 32 bits. The live RX and TX status words are set by rx_stat_set and tx_stat_set.
- R7: Writes to the live RX status (0x28) and live TX status (0x34) are ignored.
- R8: Writing a 1 to bit 0 of counter control (0x40) zeroes every RX and TX statistics counter. Bit 0 always reads back 0, and the other bits store the written value.
- R9: Any word access to offsets 0x80 to 0xFC (the time window) completes without error, has no effect and reads 0.
- R10: An access to an unmapped or misaligned offset (offset bits 1:0 not zero) returns 0 and raises the error flag for exactly one cycle. A cycle with no access never raises the error flag.
- R11: When a set pulse and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R12: Plain registers (hash 0x0C and 0x10, VLAN, system control, the interrupt enables) store and read back the full word. RX counter k sits at 0x100+4k and TX counter k at 0x180+4k. Each counter counts up by one on each cycle its increment strobe is high, and a word write loads it.
- R13: rx_en always equals mode bit 0, and tx_en always equals mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code (2 = word) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | Error flag, one cycle after the access |
| rx_en | output | 1 | Receive enable from mode bit 0 |
| tx_en | output | 1 | Transmit enable from mode bit 1 |
| rx_stat_set | input | 32 | Set pulses for live and sticky RX status |
| tx_stat_set | input | 32 | Set pulses for live and sticky TX status |
| sys_stat_set | input | 32 | Set pulses for system status |
| wake_set | input | 32 | Set pulses for the clearable wakeup bits |
| cnt_rx_irq_set | input | 32 | Set pulses for RX counter-interrupt status |
| cnt_tx_irq_set | input | 32 | Set pulses for TX counter-interrupt status |
| rx_cnt_inc | input | NRX | Increment strobes for the RX counters |
| tx_cnt_inc | input | NTX | Increment strobes for the TX counters |

## Verification
A wrong write rule leaves a register holding the wrong value. This shows on bus_rdata at the first read of that offset, one cycle after the read strobe. A missed enable-edge clear or a lost set pulse shows the same way, at the next read of the live or sticky status word. A decode fault shows as a wrong bus_err value in the cycle right after the access. A mode fault shows at once on rx_en and tx_en.

// File: rtl/emac_rb_pkg.sv
package emac_rb_pkg;

   localparam logic [1:0] SZ_WORD = 2'd2;

   // word indices (byte offset / 4)
   localparam logic [31:0] W_MODE     = 32'd0;
   localparam logic [31:0] W_ADDR_LO  = 32'd1;
   localparam logic [31:0] W_ADDR_HI  = 32'd2;
   localparam logic [31:0] W_HASH_LO  = 32'd3;
   localparam logic [31:0] W_HASH_HI  = 32'd4;
   localparam logic [31:0] W_VLAN_A   = 32'd5;
   localparam logic [31:0] W_VLAN_B   = 32'd6;
   localparam logic [31:0] W_SYS_CTL  = 32'd7;
   localparam logic [31:0] W_SYS_STAT = 32'd8;
   localparam logic [31:0] W_WAKE     = 32'd9;
   localparam logic [31:0] W_RX_LIVE  = 32'd10;
   localparam logic [31:0] W_RX_STKY  = 32'd11;
   localparam logic [31:0] W_RX_IEN   = 32'd12;
   localparam logic [31:0] W_TX_LIVE  = 32'd13;
   localparam logic [31:0] W_TX_STKY  = 32'd14;
   localparam logic [31:0] W_TX_IEN   = 32'd15;
   localparam logic [31:0] W_CNT_CTL  = 32'd16;
   localparam logic [31:0] W_CRX_IS   = 32'd17;
   localparam logic [31:0] W_CRX_IEN  = 32'd18;
   localparam logic [31:0] W_CTX_IS   = 32'd19;
   localparam logic [31:0] W_CTX_IEN  = 32'd20;
   localparam logic [31:0] W_TIME_LO  = 32'd32;
   localparam logic [31:0] W_TIME_HI  = 32'd63;
   localparam logic [31:0] W_RXCNT    = 32'd64;
   localparam logic [31:0] W_TXCNT    = 32'd96;
   localparam int          CNT_SLOTS  = 32;

   // plain (store/read-back) register slots
   localparam int P_MODE    = 0;
   localparam int P_ADDR_LO = 1;
   localparam int P_ADDR_HI = 2;
   localparam int P_HASH_LO = 3;
   localparam int P_HASH_HI = 4;
   localparam int P_VLAN_A  = 5;
   localparam int P_VLAN_B  = 6;
   localparam int P_SYS_CTL = 7;
   localparam int P_RX_IEN  = 8;
   localparam int P_TX_IEN  = 9;
   localparam int P_CNT_CTL = 10;
   localparam int P_CRX_IEN = 11;
   localparam int P_CTX_IEN = 12;
   localparam int NPLAIN    = 13;

   localparam int MODE_RX_BIT   = 0;
   localparam int MODE_TX_BIT   = 1;
   localparam int LIVE_DONE_BIT = 0;
   localparam int CNT_CLR_BIT   = 0;

   localparam logic [31:0] SYS_CLR_MASK  = 32'h0000_00E1;
   localparam logic [31:0] WAKE_CLR_MASK = 32'h0000_0F20;

   typedef enum logic [3:0] {
      S_BAD, S_PLAIN, S_SYS_STAT, S_WAKE, S_RX_LIVE, S_RX_STKY,
      S_TX_LIVE, S_TX_STKY, S_CRX_IS, S_CTX_IS, S_TIME, S_RXCNT, S_TXCNT
   } sel_e;

   function automatic logic [31:0] plain_rst(input int idx);
      case (idx)
         P_ADDR_LO: return 32'hFFFF_FFFF;
         P_ADDR_HI: return 32'h0000_FFFF;
         P_VLAN_A:  return 32'h0000_FFFF;
         P_VLAN_B:  return 32'h0000_FFFF;
         P_SYS_CTL: return 32'h0000_3F00;
         P_CNT_CTL: return 32'h0000_000A;
         default:   return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] plain_wmask(input int idx);
      if (idx == P_CNT_CTL) return ~(32'h1 << CNT_CLR_BIT);
      return 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/emac_rb_decode.sv
module emac_rb_decode
   import emac_rb_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int NRX    = 4,
   parameter int NTX    = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic [3:0]        pidx,
   output logic [4:0]        cidx
);

   logic [31:0] widx;
   logic        aligned;

   assign widx    = 32'(addr[ADDR_W-1:2]);
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      sel  = S_BAD;
      pidx = '0;
      cidx = '0;
      if (aligned) begin
         case (widx)
            W_MODE:     begin sel = S_PLAIN; pidx = 4'(P_MODE);    end
            W_ADDR_LO:  begin sel = S_PLAIN; pidx = 4'(P_ADDR_LO); end
            W_ADDR_HI:  begin sel = S_PLAIN; pidx = 4'(P_ADDR_HI); end
            W_HASH_LO:  begin sel = S_PLAIN; pidx = 4'(P_HASH_LO); end
            W_HASH_HI:  begin sel = S_PLAIN; pidx = 4'(P_HASH_HI); end
            W_VLAN_A:   begin sel = S_PLAIN; pidx = 4'(P_VLAN_A);  end
            W_VLAN_B:   begin sel = S_PLAIN; pidx = 4'(P_VLAN_B);  end
            W_SYS_CTL:  begin sel = S_PLAIN; pidx = 4'(P_SYS_CTL); end
            W_RX_IEN:   begin sel = S_PLAIN; pidx = 4'(P_RX_IEN);  end
            W_TX_IEN:   begin sel = S_PLAIN; pidx = 4'(P_TX_IEN);  end
            W_CNT_CTL:  begin sel = S_PLAIN; pidx = 4'(P_CNT_CTL); end
            W_CRX_IEN:  begin sel = S_PLAIN; pidx = 4'(P_CRX_IEN); end
            W_CTX_IEN:  begin sel = S_PLAIN; pidx = 4'(P_CTX_IEN); end
            W_SYS_STAT: sel = S_SYS_STAT;
            W_WAKE:     sel = S_WAKE;
            W_RX_LIVE:  sel = S_RX_LIVE;
            W_RX_STKY:  sel = S_RX_STKY;
            W_TX_LIVE:  sel = S_TX_LIVE;
            W_TX_STKY:  sel = S_TX_STKY;
            W_CRX_IS:   sel = S_CRX_IS;
            W_CTX_IS:   sel = S_CTX_IS;
            default: begin
               if (widx >= W_TIME_LO && widx <= W_TIME_HI) begin
                  sel = S_TIME;
               end else if (widx >= W_RXCNT && widx < W_RXCNT + 32'(NRX)) begin
                  sel  = S_RXCNT;
                  cidx = 5'(widx - W_RXCNT);
               end else if (widx >= W_TXCNT && widx < W_TXCNT + 32'(NTX)) begin
                  sel  = S_TXCNT;
                  cidx = 5'(widx - W_TXCNT);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/emac_rb_w1c.sv
module emac_rb_w1c #(
   parameter int          W          = 32,
   parameter logic [W-1:0] CLR_MASK  = '1,
   parameter logic [W-1:0] PLAIN_MASK = '0,
   parameter logic [W-1:0] RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);

   if ((CLR_MASK & PLAIN_MASK) != '0) begin : g_bad_mask
      $error("emac_rb_w1c: a bit cannot be both clearable and plain");
   end

   logic [W-1:0] nxt;

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (CLR_MASK[b]) begin : g_clr
         // set beats a simultaneous clear
         assign nxt[b] = ((wr && wdata[b]) ? 1'b0 : q[b]) | set[b];
      end else if (PLAIN_MASK[b]) begin : g_plain
         assign nxt[b] = (wr ? wdata[b] : q[b]) | set[b];
      end else begin : g_hold
         assign nxt[b] = q[b] | set[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/emac_rb_counters.sv
module emac_rb_counters #(
   parameter int N     = 4,
   parameter int CNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       inc,
   input  logic               clr_all,
   input  logic               wr,
   input  logic [4:0]         wr_idx,
   input  logic [CNT_W-1:0]   wdata,
   output logic [N*CNT_W-1:0] q
);

   if (N < 1 || N > 32) begin : g_bad_n
      $error("emac_rb_counters: N must be 1..32");
   end

   for (genvar k = 0; k < N; k++) begin : g_cnt
      logic [CNT_W-1:0] c;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          c <= '0;
         else if (clr_all)                    c <= '0;
         else if (wr && wr_idx == 5'(k))      c <= wdata;
         else if (inc[k])                     c <= c + 1'b1;
      end
      assign q[k*CNT_W +: CNT_W] = c;
   end

endmodule

// File: rtl/emac_reg_bank.sv
module emac_reg_bank
   import emac_rb_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int NRX    = 4,
   parameter int NTX    = 4,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              rx_en,
   output logic              tx_en,
   input  logic [31:0]       rx_stat_set,
   input  logic [31:0]       tx_stat_set,
   input  logic [31:0]       sys_stat_set,
   input  logic [31:0]       wake_set,
   input  logic [31:0]       cnt_rx_irq_set,
   input  logic [31:0]       cnt_tx_irq_set,
   input  logic [NRX-1:0]    rx_cnt_inc,
   input  logic [NTX-1:0]    tx_cnt_inc
);

   if (ADDR_W < 9) begin : g_bad_aw
      $error("emac_reg_bank: ADDR_W must cover the counter windows (>= 9)");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
      $error("emac_reg_bank: CNT_W must be 1..32");
   end
   if (NRX > CNT_SLOTS || NTX > CNT_SLOTS) begin : g_bad_n
      $error("emac_reg_bank: too many counters for the window");
   end

   localparam logic [31:0] LIVE_DONE = 32'h1 << LIVE_DONE_BIT;

   sel_e       sel;
   logic [3:0] pidx;
   logic [4:0] cidx;

   emac_rb_decode #(.ADDR_W(ADDR_W), .NRX(NRX), .NTX(NTX)) i_dec (
      .addr(bus_addr), .sel(sel), .pidx(pidx), .cidx(cidx)
   );

   logic size_ok, wr_ok;
   assign size_ok = (bus_size == SZ_WORD);
   assign wr_ok   = bus_wr && size_ok;

   // plain registers
   logic [31:0] plain_q [NPLAIN];

   for (genvar p = 0; p < NPLAIN; p++) begin : g_plain
      localparam logic [31:0] RV = plain_rst(p);
      localparam logic [31:0] WM = plain_wmask(p);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            plain_q[p] <= RV;
         else if (wr_ok && sel == S_PLAIN && pidx == 4'(p))
            plain_q[p] <= bus_wdata & WM;
      end
   end

   logic mode_wr, re_rise, te_rise;
   assign mode_wr = wr_ok && sel == S_PLAIN && pidx == 4'(P_MODE);
   assign re_rise = mode_wr && bus_wdata[MODE_RX_BIT] && !plain_q[P_MODE][MODE_RX_BIT];
   assign te_rise = mode_wr && bus_wdata[MODE_TX_BIT] && !plain_q[P_MODE][MODE_TX_BIT];

   assign rx_en = plain_q[P_MODE][MODE_RX_BIT];
   assign tx_en = plain_q[P_MODE][MODE_TX_BIT];

   // status words
   logic [31:0] rx_live_q, rx_stky_q, tx_live_q, tx_stky_q;
   logic [31:0] sys_stat_q, wake_q, crx_is_q, ctx_is_q;

   emac_rb_w1c #(.W(32)) i_rx_live (
      .clk, .rst_n, .wr(re_rise), .wdata(LIVE_DONE), .set(rx_stat_set), .q(rx_live_q)
   );
   emac_rb_w1c #(.W(32)) i_tx_live (
      .clk, .rst_n, .wr(te_rise), .wdata(LIVE_DONE), .set(tx_stat_set), .q(tx_live_q)
   );
   emac_rb_w1c #(.W(32)) i_rx_stky (
      .clk, .rst_n, .wr(wr_ok && sel == S_RX_STKY), .wdata(bus_wdata),
      .set(rx_stat_set), .q(rx_stky_q)
   );
   emac_rb_w1c #(.W(32)) i_tx_stky (
      .clk, .rst_n, .wr(wr_ok && sel == S_TX_STKY), .wdata(bus_wdata),
      .set(tx_stat_set), .q(tx_stky_q)
   );
   emac_rb_w1c #(.W(32), .CLR_MASK(SYS_CLR_MASK)) i_sys_stat (
      .clk, .rst_n, .wr(wr_ok && sel == S_SYS_STAT), .wdata(bus_wdata),
      .set(sys_stat_set), .q(sys_stat_q)
   );
   emac_rb_w1c #(.W(32), .CLR_MASK(WAKE_CLR_MASK), .PLAIN_MASK(~WAKE_CLR_MASK)) i_wake (
      .clk, .rst_n, .wr(wr_ok && sel == S_WAKE), .wdata(bus_wdata),
      .set(wake_set & WAKE_CLR_MASK), .q(wake_q)
   );
   emac_rb_w1c #(.W(32)) i_crx_is (
      .clk, .rst_n, .wr(wr_ok && sel == S_CRX_IS), .wdata(bus_wdata),
      .set(cnt_rx_irq_set), .q(crx_is_q)
   );
   emac_rb_w1c #(.W(32)) i_ctx_is (
      .clk, .rst_n, .wr(wr_ok && sel == S_CTX_IS), .wdata(bus_wdata),
      .set(cnt_tx_irq_set), .q(ctx_is_q)
   );

   // statistics counters
   logic                   cnt_clr;
   logic [NRX*CNT_W-1:0]   rx_cnt_q;
   logic [NTX*CNT_W-1:0]   tx_cnt_q;

   assign cnt_clr = wr_ok && sel == S_PLAIN && pidx == 4'(P_CNT_CTL)
                    && bus_wdata[CNT_CLR_BIT];

   emac_rb_counters #(.N(NRX), .CNT_W(CNT_W)) i_rx_cnt (
      .clk, .rst_n, .inc(rx_cnt_inc), .clr_all(cnt_clr),
      .wr(wr_ok && sel == S_RXCNT), .wr_idx(cidx),
      .wdata(bus_wdata[CNT_W-1:0]), .q(rx_cnt_q)
   );
   emac_rb_counters #(.N(NTX), .CNT_W(CNT_W)) i_tx_cnt (
      .clk, .rst_n, .inc(tx_cnt_inc), .clr_all(cnt_clr),
      .wr(wr_ok && sel == S_TXCNT), .wr_idx(cidx),
      .wdata(bus_wdata[CNT_W-1:0]), .q(tx_cnt_q)
   );

   // read mux
   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      case (sel)
         S_PLAIN:    rd_val = plain_q[pidx];
         S_SYS_STAT: rd_val = sys_stat_q;
         S_WAKE:     rd_val = wake_q;
         S_RX_LIVE:  rd_val = rx_live_q;
         S_RX_STKY:  rd_val = rx_stky_q;
         S_TX_LIVE:  rd_val = tx_live_q;
         S_TX_STKY:  rd_val = tx_stky_q;
         S_CRX_IS:   rd_val = crx_is_q;
         S_CTX_IS:   rd_val = ctx_is_q;
         S_RXCNT:    rd_val[CNT_W-1:0] = rx_cnt_q[cidx*CNT_W +: CNT_W];
         S_TXCNT:    rd_val[CNT_W-1:0] = tx_cnt_q[cidx*CNT_W +: CNT_W];
         default:    rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err   <= (bus_wr || bus_rd) && (!size_ok || sel == S_BAD);
         bus_rdata <= (bus_rd && size_ok && sel != S_BAD) ? rd_val : '0;
      end
   end

endmodule

// File: rtl/emac_rb_checker.sv
module emac_rb_checker
   import emac_rb_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic              rx_en,
   input logic              tx_en,
   input logic [31:0]       rx_stat_set,
   input logic [31:0]       rx_live,
   input logic [31:0]       rx_sticky
);

   localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(W_MODE << 2);
   localparam logic [ADDR_W-1:0] A_RX_LIVE = ADDR_W'(W_RX_LIVE << 2);
   localparam logic [ADDR_W-1:0] A_CNT_CTL = ADDR_W'(W_CNT_CTL << 2);
   localparam logic [ADDR_W-1:0] A_T_LO    = ADDR_W'(W_TIME_LO << 2);
   localparam logic [ADDR_W-1:0] A_T_HI    = ADDR_W'(W_TIME_HI << 2);

   logic acc, word;
   assign acc  = bus_wr || bus_rd;
   assign word = (bus_size == SZ_WORD);

   AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !word |=> bus_err && bus_rdata == 32'h0); // R1

   AST_SIZE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !word |=> $stable(rx_en) && $stable(tx_en)); // R1

   AST_RX_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && word && bus_addr == A_MODE && bus_wdata[MODE_RX_BIT] && !rx_en
      && !rx_stat_set[LIVE_DONE_BIT] |=> !rx_live[LIVE_DONE_BIT]); // R3

   AST_LIVE_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && word && bus_addr == A_RX_LIVE && rx_stat_set == 32'h0
      |=> rx_live == $past(rx_live)); // R7

   AST_CNT_CTL_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && word && bus_addr == A_CNT_CTL |=> !bus_rdata[CNT_CLR_BIT]); // R8

   AST_TIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && word && bus_addr >= A_T_LO && bus_addr <= A_T_HI && bus_addr[1:0] == 2'b00
      |=> !bus_err && bus_rdata == 32'h0); // R9

   AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !bus_err); // R10

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_set != 32'h0 |=> (rx_sticky & $past(rx_stat_set)) == $past(rx_stat_set)); // R11

endmodule

bind emac_reg_bank emac_rb_checker #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_en(rx_en), .tx_en(tx_en),
   .rx_stat_set(rx_stat_set), .rx_live(rx_live_q), .rx_sticky(rx_stky_q)
);

// File: tb/test_emac_reg_bank.sv
module test_emac_reg_bank;

   localparam int AW  = 9;
   localparam int NRX = 4;
   localparam int NTX = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0]    bus_size = 2'd2;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err, rx_en, tx_en;
   logic [31:0]   rx_set = '0, tx_set = '0, sys_set = '0, wk_set = '0;
   logic [31:0]   crx_set = '0, ctx_set = '0;
   logic [NRX-1:0] rx_inc = '0;
   logic [NTX-1:0] tx_inc = '0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   emac_reg_bank #(.ADDR_W(AW), .NRX(NRX), .NTX(NTX), .CNT_W(32)) i_emac_reg_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_en(rx_en), .tx_en(tx_en),
      .rx_stat_set(rx_set), .tx_stat_set(tx_set), .sys_stat_set(sys_set),
      .wake_set(wk_set), .cnt_rx_irq_set(crx_set), .cnt_tx_irq_set(ctx_set),
      .rx_cnt_inc(rx_inc), .tx_cnt_inc(tx_inc)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [8:0]  addr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic        err;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd2, 9'h004, 32'h0,        32'hFFFF_FFFF, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h008, 32'h0,        32'h0000_FFFF, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h014, 32'h0,        32'h0000_FFFF, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h018, 32'h0,        32'h0000_FFFF, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h01C, 32'h0,        32'h0000_3F00, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h040, 32'h0,        32'h0000_000A, 1'b0}, // R2
      '{1'b0, 2'd2, 9'h000, 32'h0,        32'h0,         1'b0}, // R2
      '{1'b1, 2'd2, 9'h00C, 32'h1234_5678, 32'h0,        1'b0}, // R12
      '{1'b0, 2'd2, 9'h00C, 32'h0,        32'h1234_5678, 1'b0}, // R12
      '{1'b0, 2'd1, 9'h00C, 32'h0,        32'h0,         1'b1}, // R1
      '{1'b1, 2'd0, 9'h00C, 32'h0,        32'h0,         1'b1}, // R1
      '{1'b0, 2'd2, 9'h00C, 32'h0,        32'h1234_5678, 1'b0}, // R1
      '{1'b0, 2'd1, 9'h080, 32'h0,        32'h0,         1'b1}, // R1
      '{1'b0, 2'd0, 9'h054, 32'h0,        32'h0,         1'b1}, // R1
      '{1'b1, 2'd2, 9'h080, 32'hDEAD_BEEF, 32'h0,        1'b0}, // R9
      '{1'b0, 2'd2, 9'h080, 32'h0,        32'h0,         1'b0}, // R9
      '{1'b0, 2'd2, 9'h0FC, 32'h0,        32'h0,         1'b0}, // R9
      '{1'b0, 2'd2, 9'h054, 32'h0,        32'h0,         1'b1}, // R10
      '{1'b1, 2'd2, 9'h060, 32'h1,        32'h0,         1'b1}, // R10
      '{1'b0, 2'd2, 9'h110, 32'h0,        32'h0,         1'b1}, // R10
      '{1'b0, 2'd2, 9'h006, 32'h0,        32'h0,         1'b1}, // R10
      '{1'b0, 2'd2, 9'h190, 32'h0,        32'h0,         1'b1}, // R10
      '{1'b1, 2'd2, 9'h028, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R7
      '{1'b0, 2'd2, 9'h028, 32'h0,        32'h0,         1'b0}, // R7
      '{1'b1, 2'd2, 9'h034, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R7
      '{1'b0, 2'd2, 9'h034, 32'h0,        32'h0,         1'b0}, // R7
      '{1'b1, 2'd2, 9'h040, 32'h0000_000F, 32'h0,        1'b0}, // R8
      '{1'b0, 2'd2, 9'h040, 32'h0,        32'h0000_000E, 1'b0}, // R8
      '{1'b1, 2'd2, 9'h024, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R5
      '{1'b0, 2'd2, 9'h024, 32'h0,        32'hFFFF_F0DF, 1'b0}, // R5
      '{1'b1, 2'd2, 9'h018, 32'h0000_0ABC, 32'h0,        1'b0}, // R12
      '{1'b0, 2'd2, 9'h018, 32'h0,        32'h0000_0ABC, 1'b0}  // R12
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd, output logic [31:0] rd, output logic er);
      @(negedge clk);
      bus_wr = wr; bus_rd = !wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      rd = bus_rdata; er = bus_err;
   endtask

   task automatic wr32(input logic [AW-1:0] a, input logic [31:0] wd);
      logic [31:0] r; logic e;
      access(1'b1, 2'd2, a, wd, r, e);
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] r; logic e;
      access(1'b0, 2'd2, a, 32'h0, r, e);
      check(req, r, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [31:0] r;
      logic        e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 rx_en/tx_en after reset", {30'h0, rx_en, tx_en}, 32'h0);
      check("R10 err idle after reset", {31'h0, bus_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd, r, e);
         check($sformatf("vector %0d err", i), {31'h0, e}, {31'h0, VEC[i].err});
         if (!VEC[i].wr) check($sformatf("vector %0d rdata", i), r, VEC[i].exp);
      end

      // R10: error lasts one cycle only
      @(negedge clk); bus_rd = 1'b1; bus_addr = 9'h054;
      @(negedge clk); bus_rd = 1'b0;
      check("R10 err raised", {31'h0, bus_err}, 32'h1);
      @(negedge clk);
      check("R10 err dropped", {31'h0, bus_err}, 32'h0);

      // R12: counters count and load
      @(negedge clk); rx_inc = 4'b0011; tx_inc = 4'b0100;
      @(negedge clk);
      @(negedge clk); tx_inc = '0;
      @(negedge clk); rx_inc = '0;
      rd_chk("R12 rx counter 0", 9'h100, 32'd3);
      rd_chk("R12 rx counter 1", 9'h104, 32'd3);
      rd_chk("R12 rx counter 2", 9'h108, 32'd0);
      rd_chk("R12 tx counter 2", 9'h188, 32'd2);
      wr32(9'h104, 32'h10);
      @(negedge clk); rx_inc = 4'b0010;
      @(negedge clk); rx_inc = '0;
      rd_chk("R12 rx counter load+inc", 9'h104, 32'h11);

      // R8: clear all counters
      wr32(9'h040, 32'h1);
      rd_chk("R8 rx counter cleared", 9'h100, 32'h0);
      rd_chk("R8 tx counter cleared", 9'h188, 32'h0);
      rd_chk("R8 ctl bit0 reads 0", 9'h040, 32'h0);

      // R6 / R7: live and sticky RX
      @(negedge clk); rx_set = 32'h5;
      @(negedge clk); rx_set = '0;
      rd_chk("R6 rx live set", 9'h028, 32'h5);
      rd_chk("R6 rx sticky set", 9'h02C, 32'h5);
      wr32(9'h02C, 32'h4);
      rd_chk("R6 rx sticky w1c", 9'h02C, 32'h1);
      wr32(9'h028, 32'h0);
      rd_chk("R7 rx live unchanged", 9'h028, 32'h5);

      // R3 / R13: enable edges
      wr32(9'h000, 32'h1);
      rd_chk("R3 rx done cleared on edge", 9'h028, 32'h4);
      check("R13 rx_en/tx_en", {30'h0, tx_en, rx_en}, 32'h1);
      @(negedge clk); rx_set = 32'h1;
      @(negedge clk); rx_set = '0;
      wr32(9'h000, 32'h1);
      rd_chk("R3 no edge keeps rx done", 9'h028, 32'h5);
      @(negedge clk); tx_set = 32'h3;
      @(negedge clk); tx_set = '0;
      wr32(9'h000, 32'h3);
      rd_chk("R3 rx untouched by tx edge", 9'h028, 32'h5);
      rd_chk("R3 tx done cleared on edge", 9'h034, 32'h2);
      check("R13 both enables", {30'h0, tx_en, rx_en}, 32'h3);

      // R11: set beats clear
      @(negedge clk);
      bus_wr = 1'b1; bus_size = 2'd2; bus_addr = 9'h02C; bus_wdata = 32'hFFFF_FFFF;
      rx_set = 32'h10;
      @(negedge clk);
      bus_wr = 1'b0; rx_set = '0;
      rd_chk("R11 set wins over w1c", 9'h02C, 32'h10);

      // R4: system status masked w1c
      @(negedge clk); sys_set = 32'hFFFF_FFFF;
      @(negedge clk); sys_set = '0;
      wr32(9'h020, 32'hFFFF_FFFF);
      rd_chk("R4 sys status masked clear", 9'h020, 32'hFFFF_FF1E);

      // R5: wakeup control mixed rule
      @(negedge clk); wk_set = 32'hFFFF_FFFF;
      @(negedge clk); wk_set = '0;
      rd_chk("R5 wake set", 9'h024, 32'hFFFF_FFFF);
      wr32(9'h024, 32'h0000_0120);
      rd_chk("R5 wake mixed write", 9'h024, 32'h0000_0E00);

      // R6: counter interrupt status
      @(negedge clk); crx_set = 32'hFF; ctx_set = 32'h0F00;
      @(negedge clk); crx_set = '0; ctx_set = '0;
      wr32(9'h044, 32'h0F);
      rd_chk("R6 rx counter irq w1c", 9'h044, 32'hF0);
      wr32(9'h04C, 32'hFFFF_FFFF);
      rd_chk("R6 tx counter irq w1c", 9'h04C, 32'h0);

      // R2: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      check("R2 enables after reset", {30'h0, tx_en, rx_en}, 32'h0);
      rd_chk("R2 addr lo after reset", 9'h004, 32'hFFFF_FFFF);
      rd_chk("R2 rx live after reset", 9'h028, 32'h0);

      finish_run();
   end

endmodule